// File: doc/BRIEF.md
# External Memory Access Sequencer

This block is the single bus master between a processor pipeline and external memory. It serves one access at a time. The requesters are an uncached instruction fetch, an uncached load or store, a fill from the instruction cache or the data cache after a miss, and a trip through the peripheral bridge. While an access is open, the block drives a one-hot chip select for the addressed memory bank and places the address on either the instruction-side or the data-side address output. On a store it also drives the write strobe and the data.

Each memory bank has its own wait-state count, held in a packed configuration input. An uncached access keeps its chip select active for that count plus one cycle. It then returns read data and raises a one-cycle done pulse. During a cache fill, the cache's miss handler sequences the individual words. The block only gates the chip select with that cache's wait-for-memory flag, and it leaves the state when the cache reports completion. A peripheral access stays open until the bridge reports ready.

Top module: `ext_mem_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it, all chip selects, `mem_we`, both address outputs, all done pulses and both read-data outputs are zero.
- R2: With `icache_en` low, a held `if_req` starts an instruction access. `if_rdata` then returns the memory word read at `if_addr`, and `if_done` pulses for one cycle. With `icache_en` high, `if_req` produces no chip select, no address and no `if_done`.
- R3: With `dcache_en` low, a held `ls_req` starts a data access. A load (`ls_we`=0) returns the word at `ls_addr` on `ls_rdata`. A store (`ls_we`=1) drives `mem_we`=1 and `mem_wdata`=`ls_wdata` throughout the access. `ls_done` pulses once either way. With `dcache_en` high, `ls_req` has no effect.
- R4: The bank index is address bits [30:28]; bit 31 does not affect it. The wait count of bank b is `cfg_wait[4b+3:4b]`. During an uncached access, `mem_cs` bit b stays high for exactly wait+1 cycles, so a count of zero gives a single-cycle access. The done pulse comes in the cycle after the last chip-select cycle.
- R5: During an instruction-cache fill (`ic_miss`), `imem_addr` follows `ic_addr`. `mem_cs` selects the bank of `ic_addr` only while `ic_wait_mem` is high and is zero otherwise. `ic_done` returns the block to idle at the next edge.
- R6: During a data-cache fill (`dc_miss`), `dmem_addr` follows `dc_addr`. The chip select for the bank of `dc_addr`, and `mem_we`=`dc_we`, are active only while `dc_wait_mem` is high. `mem_wdata` is `dc_wdata` when `dc_we` is high. `dc_done` returns the block to idle at the next edge.
- R7: `pb_sel` opens a peripheral access. No chip select or address is driven during it. The access stays open while `pb_ready` is low, and `pb_done` pulses in the cycle after `pb_ready` is seen high.
- R8: When several requests are pending in idle, the order of service is data-cache fill, instruction-cache fill, peripheral, uncached data, uncached fetch.
- R9: `imem_addr` is zero outside instruction accesses and instruction-cache fills. `dmem_addr` is zero outside data accesses and data-cache fills.
- R10: `mem_cs` never has more than one bit set and is all zero in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wait | input | 32 | Eight 4-bit wait counts, bank b at bits [4b+3:4b] |
| icache_en | input | 1 | Instruction cache enabled; uncached fetches are not served |
| dcache_en | input | 1 | Data cache enabled; uncached loads/stores are not served |
| if_req | input | 1 | Uncached fetch request, held until `if_done` |
| if_addr | input | 32 | Fetch address |
| if_rdata | output | 32 | Fetched word |
| if_done | output | 1 | Fetch complete pulse |
| ls_req | input | 1 | Uncached load/store request, held until `ls_done` |
| ls_we | input | 1 | 1 = store, 0 = load |
| ls_addr | input | 32 | Load/store address |
| ls_wdata | input | 32 | Store data |
| ls_rdata | output | 32 | Loaded word |
| ls_done | output | 1 | Load/store complete pulse |
| ic_miss | input | 1 | Instruction cache fill request |
| ic_addr | input | 32 | Address of the current fill word |
| ic_wait_mem | input | 1 | Instruction cache is waiting on memory this cycle |
| ic_done | input | 1 | Instruction cache fill finished |
| dc_miss | input | 1 | Data cache fill / write-back request |
| dc_addr | input | 32 | Address of the current fill or write-back word |
| dc_we | input | 1 | Current data cache word is a write-back |
| dc_wdata | input | 32 | Write-back data |
| dc_wait_mem | input | 1 | Data cache is waiting on memory this cycle |
| dc_done | input | 1 | Data cache fill finished |
| pb_sel | input | 1 | Peripheral access request |
| pb_ready | input | 1 | Bridge has finished the peripheral access |
| pb_done | output | 1 | Peripheral access complete pulse |
| mem_rdata | input | 32 | Read data from external memory |
| mem_cs | output | 8 | One-hot bank chip selects |
| imem_addr | output | 32 | Instruction-side external address |
| dmem_addr | output | 32 | Data-side external address |
| mem_we | output | 1 | External write strobe |
| mem_wdata | output | 32 | External write data |

## Verification
A request raised before clock edge E puts the block in its access state at E. For an uncached access to a bank with count w, the chip select and address are visible for the w+1 cycles that follow. The done pulse and the read data appear one cycle later, together. The bench drives every input on the falling edge and samples on the falling edge. It counts chip-select cycles until the done pulse, so the count is compared with w+1 exactly. Cache-fill and peripheral-ready outputs follow their inputs within the same cycle while the block is in the matching state. The bench therefore changes those inputs, waits a fraction of a cycle and compares at once. Exits to idle are checked one edge later.

// File: rtl/ems_pkg.sv
package ems_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INSTR  = 3'd1,
    ST_DATA   = 3'd2,
    ST_ICACHE = 3'd3,
    ST_DCACHE = 3'd4,
    ST_PERIPH = 3'd5
  } ems_state_e;
endpackage

// File: rtl/ems_arbiter.sv
module ems_arbiter
  import ems_pkg::*;
(
  input  logic       dc_req,
  input  logic       ic_req,
  input  logic       pb_req,
  input  logic       ls_req,
  input  logic       if_req,
  output ems_state_e pick
);
  always_comb begin
    if (dc_req)      pick = ST_DCACHE;
    else if (ic_req) pick = ST_ICACHE;
    else if (pb_req) pick = ST_PERIPH;
    else if (ls_req) pick = ST_DATA;
    else if (if_req) pick = ST_INSTR;
    else             pick = ST_IDLE;
  end
endmodule

// File: rtl/ems_wait_lookup.sv
module ems_wait_lookup #(
  parameter int NUM_BANKS = 8,
  parameter int WAIT_W    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg,
  input  logic [BANK_W-1:0]           bank,
  output logic [WAIT_W-1:0]           wait_val
);
  logic [WAIT_W-1:0] tbl [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_tbl
    assign tbl[g] = cfg[g*WAIT_W +: WAIT_W];
  end

  assign wait_val = tbl[bank];
endmodule

// File: rtl/ems_bank_dec.sv
module ems_bank_dec #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 en,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] cs
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign cs[g] = en && (bank == BANK_W'(g));
  end
endmodule

// File: rtl/ems_wait_ctr.sv
module ems_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int WAIT_W    = 4,
  parameter int BANK_LSB  = 28
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait,
  input  logic                        icache_en,
  input  logic                        dcache_en,
  input  logic                        if_req,
  input  logic [ADDR_W-1:0]           if_addr,
  output logic [DATA_W-1:0]           if_rdata,
  output logic                        if_done,
  input  logic                        ls_req,
  input  logic                        ls_we,
  input  logic [ADDR_W-1:0]           ls_addr,
  input  logic [DATA_W-1:0]           ls_wdata,
  output logic [DATA_W-1:0]           ls_rdata,
  output logic                        ls_done,
  input  logic                        ic_miss,
  input  logic [ADDR_W-1:0]           ic_addr,
  input  logic                        ic_wait_mem,
  input  logic                        ic_done,
  input  logic                        dc_miss,
  input  logic [ADDR_W-1:0]           dc_addr,
  input  logic                        dc_we,
  input  logic [DATA_W-1:0]           dc_wdata,
  input  logic                        dc_wait_mem,
  input  logic                        dc_done,
  input  logic                        pb_sel,
  input  logic                        pb_ready,
  output logic                        pb_done,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic [NUM_BANKS-1:0]        mem_cs,
  output logic [ADDR_W-1:0]           imem_addr,
  output logic [ADDR_W-1:0]           dmem_addr,
  output logic                        mem_we,
  output logic [DATA_W-1:0]           mem_wdata
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  ems_state_e          st_q;
  ems_state_e          pick;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   if_rdata_q, ls_rdata_q;
  logic                if_done_q, ls_done_q, pb_done_q;
  logic [ADDR_W-1:0]   req_addr;
  logic [WAIT_W-1:0]   req_wait;
  logic                expired;
  logic                cs_en;
  logic [BANK_W-1:0]   cs_bank;

  // request qualification and priority pick
  ems_arbiter u_arb (
    .dc_req (dc_miss),
    .ic_req (ic_miss),
    .pb_req (pb_sel),
    .ls_req (ls_req & ~dcache_en),
    .if_req (if_req & ~icache_en),
    .pick   (pick)
  );

  assign req_addr = (pick == ST_DATA) ? ls_addr : if_addr;

  ems_wait_lookup #(.NUM_BANKS(NUM_BANKS), .WAIT_W(WAIT_W)) u_wait (
    .cfg      (cfg_wait),
    .bank     (req_addr[BANK_LSB +: BANK_W]),
    .wait_val (req_wait)
  );

  // counter reloads every idle cycle, runs down during the access
  ems_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (st_q == ST_IDLE),
    .load_val (req_wait),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      if_rdata_q <= '0;
      ls_rdata_q <= '0;
      if_done_q  <= 1'b0;
      ls_done_q  <= 1'b0;
      pb_done_q  <= 1'b0;
    end else begin
      if_done_q <= 1'b0;
      ls_done_q <= 1'b0;
      pb_done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          st_q <= pick;
          if (pick == ST_INSTR || pick == ST_DATA) begin
            addr_q  <= req_addr;
            we_q    <= (pick == ST_DATA) && ls_we;
            wdata_q <= ls_wdata;
          end
        end
        ST_INSTR: if (expired) begin
          st_q       <= ST_IDLE;
          if_done_q  <= 1'b1;
          if_rdata_q <= mem_rdata;
        end
        ST_DATA: if (expired) begin
          st_q      <= ST_IDLE;
          ls_done_q <= 1'b1;
          if (!we_q) ls_rdata_q <= mem_rdata;
        end
        ST_ICACHE: if (ic_done) st_q <= ST_IDLE;
        ST_DCACHE: if (dc_done) st_q <= ST_IDLE;
        ST_PERIPH: if (pb_ready) begin
          st_q      <= ST_IDLE;
          pb_done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // chip select and address steering
  always_comb begin
    cs_en   = 1'b0;
    cs_bank = addr_q[BANK_LSB +: BANK_W];
    unique case (st_q)
      ST_INSTR, ST_DATA: cs_en = 1'b1;
      ST_ICACHE: begin
        cs_en   = ic_wait_mem;
        cs_bank = ic_addr[BANK_LSB +: BANK_W];
      end
      ST_DCACHE: begin
        cs_en   = dc_wait_mem;
        cs_bank = dc_addr[BANK_LSB +: BANK_W];
      end
      default: cs_en = 1'b0;
    endcase
  end

  ems_bank_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .en   (cs_en),
    .bank (cs_bank),
    .cs   (mem_cs)
  );

  always_comb begin
    imem_addr = '0;
    dmem_addr = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (st_q)
      ST_INSTR:  imem_addr = addr_q;
      ST_ICACHE: imem_addr = ic_addr;
      ST_DATA: begin
        dmem_addr = addr_q;
        mem_we    = we_q;
        if (we_q) mem_wdata = wdata_q;
      end
      ST_DCACHE: begin
        dmem_addr = dc_addr;
        mem_we    = dc_we && dc_wait_mem;
        if (dc_we) mem_wdata = dc_wdata;
      end
      default: ;
    endcase
  end

  assign if_rdata = if_rdata_q;
  assign ls_rdata = ls_rdata_q;
  assign if_done  = if_done_q;
  assign ls_done  = ls_done_q;
  assign pb_done  = pb_done_q;
endmodule

// File: rtl/ext_mem_seq_chk.sv
module ext_mem_seq_chk
  import ems_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input ems_state_e           st,
  input logic [NUM_BANKS-1:0] mem_cs,
  input logic [ADDR_W-1:0]    imem_addr,
  input logic [ADDR_W-1:0]    dmem_addr,
  input logic                 if_done,
  input logic                 ls_done,
  input logic                 pb_done,
  input logic                 ic_wait_mem,
  input logic                 dc_done,
  input logic                 pb_ready
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_cs)); // R10
  AST_IDLE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (mem_cs == '0)); // R10
  AST_IF_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
    if_done |-> ($past(st) == ST_INSTR)); // R2
  AST_LS_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
    ls_done |-> ($past(st) == ST_DATA)); // R3
  AST_IC_CS_GATED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ICACHE && !ic_wait_mem) |-> (mem_cs == '0)); // R5
  AST_DC_EXIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DCACHE && dc_done) |=> (st == ST_IDLE)); // R6
  AST_PB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PERIPH && !pb_ready) |=> (st == ST_PERIPH)); // R7
  AST_PB_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
    pb_done |-> ($past(st) == ST_PERIPH)); // R7
  AST_IADDR_SCOPE: assert property (@(posedge clk) disable iff (rst)
    (st != ST_INSTR && st != ST_ICACHE) |-> (imem_addr == '0)); // R9
  AST_DADDR_SCOPE: assert property (@(posedge clk) disable iff (rst)
    (st != ST_DATA && st != ST_DCACHE) |-> (dmem_addr == '0)); // R9
endmodule

bind ext_mem_seq ext_mem_seq_chk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st          (st_q),
  .mem_cs      (mem_cs),
  .imem_addr   (imem_addr),
  .dmem_addr   (dmem_addr),
  .if_done     (if_done),
  .ls_done     (ls_done),
  .pb_done     (pb_done),
  .ic_wait_mem (ic_wait_mem),
  .dc_done     (dc_done),
  .pb_ready    (pb_ready)
);

// File: tb/ext_mem_seq_bench.sv
module ext_mem_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cfg_wait;
  logic        icache_en, dcache_en;
  logic        if_req;   logic [31:0] if_addr;  logic [31:0] if_rdata; logic if_done;
  logic        ls_req, ls_we; logic [31:0] ls_addr, ls_wdata, ls_rdata; logic ls_done;
  logic        ic_miss, ic_wait_mem, ic_done; logic [31:0] ic_addr;
  logic        dc_miss, dc_we, dc_wait_mem, dc_done; logic [31:0] dc_addr, dc_wdata;
  logic        pb_sel, pb_ready, pb_done;
  logic [31:0] mem_rdata;
  logic [7:0]  mem_cs;
  logic [31:0] imem_addr, dmem_addr, mem_wdata;
  logic        mem_we;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_wait(input logic [31:0] a);
    return (int'(a[30:28]) * 3) % 16;
  endfunction

  assign mem_rdata = mem_word(imem_addr | dmem_addr);

  ext_mem_seq u_ext_mem_seq (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .icache_en(icache_en), .dcache_en(dcache_en),
    .if_req(if_req), .if_addr(if_addr), .if_rdata(if_rdata), .if_done(if_done),
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .ls_rdata(ls_rdata), .ls_done(ls_done),
    .ic_miss(ic_miss), .ic_addr(ic_addr), .ic_wait_mem(ic_wait_mem), .ic_done(ic_done),
    .dc_miss(dc_miss), .dc_addr(dc_addr), .dc_we(dc_we), .dc_wdata(dc_wdata),
    .dc_wait_mem(dc_wait_mem), .dc_done(dc_done),
    .pb_sel(pb_sel), .pb_ready(pb_ready), .pb_done(pb_done),
    .mem_rdata(mem_rdata), .mem_cs(mem_cs), .imem_addr(imem_addr), .dmem_addr(dmem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R1: reset state
  task automatic t_reset;
    rst = 1'b1;
    step(); step();
    check(mem_cs == 8'h00, "R1", "cs in reset", {24'h0, mem_cs}, 32'h0);
    check(imem_addr == 0 && dmem_addr == 0, "R1", "addr in reset", imem_addr | dmem_addr, 32'h0);
    check({if_done, ls_done, pb_done, mem_we} == 4'b0, "R1", "pulses in reset",
          {28'h0, if_done, ls_done, pb_done, mem_we}, 32'h0);
    check(if_rdata == 0 && ls_rdata == 0, "R1", "rdata in reset", if_rdata | ls_rdata, 32'h0);
    rst = 1'b0;
    step();
    check(mem_cs == 8'h00 && !if_done && !ls_done && !pb_done, "R1", "first cycle after reset",
          {24'h0, mem_cs}, 32'h0);
  endtask

  // R2/R3/R4: one uncached access, counting chip-select cycles
  task automatic t_uncached(input bit is_data, input bit we, input logic [31:0] a,
                            input logic [31:0] wd);
    int  cyc = 0;
    int  guard = 0;
    bit  sig_ok = 1'b1;
    bit  done_seen = 1'b0;
    logic [7:0] exp_cs = 8'h01 << a[30:28];
    if (is_data) begin
      ls_req = 1'b1; ls_we = we; ls_addr = a; ls_wdata = wd;
    end else begin
      if_req = 1'b1; if_addr = a;
    end
    while (!done_seen && guard < 40) begin
      step();
      guard++;
      done_seen = is_data ? ls_done : if_done;
      if (!done_seen) begin
        if (mem_cs == exp_cs) cyc++;
        if (is_data) begin
          if (dmem_addr != a || imem_addr != 0 || mem_we != we) sig_ok = 1'b0;
          if (we && mem_wdata != wd) sig_ok = 1'b0;
        end else begin
          if (imem_addr != a || dmem_addr != 0 || mem_we) sig_ok = 1'b0;
        end
      end
    end
    check(done_seen, is_data ? "R3" : "R2", "done pulse seen", {31'h0, done_seen}, 32'h1);
    check(cyc == exp_wait(a) + 1, "R4", "chip-select cycles", cyc, exp_wait(a) + 1);
    check(sig_ok, is_data ? "R3" : "R2", "address/strobe during access", {31'h0, sig_ok}, 32'h1);
    if (!is_data)
      check(if_rdata == mem_word(a), "R2", "fetched word", if_rdata, mem_word(a));
    else if (!we)
      check(ls_rdata == mem_word(a), "R3", "loaded word", ls_rdata, mem_word(a));
    if_req = 1'b0; ls_req = 1'b0; ls_we = 1'b0;
    step();
    check(mem_cs == 8'h00 && !if_done && !ls_done, "R10", "idle after access",
          {24'h0, mem_cs}, 32'h0);
  endtask

  // R2/R3: requests ignored while the matching cache is enabled
  task automatic t_ignored(input bit is_data);
    bit quiet = 1'b1;
    if (is_data) begin
      dcache_en = 1'b1; ls_req = 1'b1; ls_addr = 32'h2000_0000;
    end else begin
      icache_en = 1'b1; if_req = 1'b1; if_addr = 32'h2000_0000;
    end
    for (int i = 0; i < 6; i++) begin
      step();
      if (mem_cs != 0 || imem_addr != 0 || dmem_addr != 0 || if_done || ls_done) quiet = 1'b0;
    end
    check(quiet, is_data ? "R3" : "R2", "request ignored with cache enabled", {31'h0, quiet}, 32'h1);
    if_req = 1'b0; ls_req = 1'b0; icache_en = 1'b0; dcache_en = 1'b0;
    step();
  endtask

  // R5: instruction cache fill
  task automatic t_icache;
    ic_miss = 1'b1; ic_addr = 32'h2000_0040; ic_wait_mem = 1'b0;
    step();
    check(mem_cs == 8'h00, "R5", "cs gated while not waiting", {24'h0, mem_cs}, 32'h0);
    check(imem_addr == 32'h2000_0040 && dmem_addr == 0, "R5", "fill address", imem_addr, 32'h2000_0040);
    ic_wait_mem = 1'b1; #1;
    check(mem_cs == 8'h04, "R5", "cs for bank 2", {24'h0, mem_cs}, 32'h4);
    ic_addr = 32'h7000_0000; #1;
    check(mem_cs == 8'h80, "R5", "cs follows live address", {24'h0, mem_cs}, 32'h80);
    step();
    ic_done = 1'b1; ic_miss = 1'b0; ic_wait_mem = 1'b0;
    step();
    ic_done = 1'b0;
    check(mem_cs == 8'h00 && imem_addr == 0, "R9", "instruction address cleared after fill",
          imem_addr, 32'h0);
  endtask

  // R6: data cache write-back word
  task automatic t_dcache;
    dc_miss = 1'b1; dc_addr = 32'h3000_0100; dc_we = 1'b1; dc_wdata = 32'hCAFE_0001;
    dc_wait_mem = 1'b0;
    step();
    check(mem_cs == 8'h00 && !mem_we, "R6", "cs/we gated while not waiting", {24'h0, mem_cs}, 32'h0);
    dc_wait_mem = 1'b1; #1;
    check(mem_cs == 8'h08 && mem_we, "R6", "cs bank 3 with write", {23'h0, mem_we, mem_cs}, 32'h108);
    check(mem_wdata == 32'hCAFE_0001, "R6", "write-back data", mem_wdata, 32'hCAFE_0001);
    check(dmem_addr == 32'h3000_0100 && imem_addr == 0, "R9", "data address in fill",
          dmem_addr, 32'h3000_0100);
    dc_done = 1'b1; dc_miss = 1'b0; dc_wait_mem = 1'b0; dc_we = 1'b0;
    step();
    dc_done = 1'b0;
    check(mem_cs == 8'h00 && dmem_addr == 0, "R6", "idle after dcache done", dmem_addr, 32'h0);
  endtask

  // R7: peripheral access waits on ready
  task automatic t_periph;
    bit quiet = 1'b1;
    pb_sel = 1'b1; pb_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (pb_done || mem_cs != 0 || imem_addr != 0 || dmem_addr != 0) quiet = 1'b0;
    end
    check(quiet, "R7", "held while bridge not ready", {31'h0, quiet}, 32'h1);
    pb_ready = 1'b1;
    step();
    check(pb_done, "R7", "done after ready", {31'h0, pb_done}, 32'h1);
    pb_sel = 1'b0; pb_ready = 1'b0;
    step();
    check(!pb_done, "R7", "done is one cycle", {31'h0, pb_done}, 32'h0);
  endtask

  task automatic wait_flag(input int which);
    int g = 0;
    while (g < 40 && !((which == 0) ? ls_done : if_done)) begin
      step(); g++;
    end
  endtask

  // R8: all five requests raised together
  task automatic t_priority;
    dc_miss = 1'b1; dc_addr = 32'h1000_0008; dc_wait_mem = 1'b1;
    ic_miss = 1'b1; ic_addr = 32'h6000_0010; ic_wait_mem = 1'b1;
    pb_sel = 1'b1; pb_ready = 1'b0;
    ls_req = 1'b1; ls_we = 1'b0; ls_addr = 32'h0000_0200;
    if_req = 1'b1; if_addr = 32'h0000_0300;
    step();
    check(dmem_addr == 32'h1000_0008 && mem_cs == 8'h02, "R8", "dcache fill first", dmem_addr, 32'h1000_0008);
    dc_done = 1'b1; dc_miss = 1'b0; dc_wait_mem = 1'b0;
    step(); dc_done = 1'b0;
    step();
    check(imem_addr == 32'h6000_0010 && mem_cs == 8'h40, "R8", "icache fill second", imem_addr, 32'h6000_0010);
    ic_done = 1'b1; ic_miss = 1'b0; ic_wait_mem = 1'b0;
    step(); ic_done = 1'b0;
    step();
    check(mem_cs == 0 && imem_addr == 0 && dmem_addr == 0, "R8", "peripheral third",
          imem_addr | dmem_addr, 32'h0);
    pb_ready = 1'b1;
    step();
    check(pb_done, "R8", "peripheral completes", {31'h0, pb_done}, 32'h1);
    pb_sel = 1'b0; pb_ready = 1'b0;
    step();
    check(dmem_addr == 32'h0000_0200 && imem_addr == 0, "R8", "uncached data fourth", dmem_addr, 32'h0000_0200);
    wait_flag(0);
    ls_req = 1'b0;
    step();
    check(imem_addr == 32'h0000_0300, "R8", "uncached fetch last", imem_addr, 32'h0000_0300);
    wait_flag(1);
    check(if_rdata == mem_word(32'h0000_0300), "R8", "fetch data after priority run",
          if_rdata, mem_word(32'h0000_0300));
    if_req = 1'b0;
    step();
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) cfg_wait[b*4 +: 4] = 4'((b * 3) % 16);
    icache_en = 0; dcache_en = 0;
    if_req = 0; if_addr = 0; ls_req = 0; ls_we = 0; ls_addr = 0; ls_wdata = 0;
    ic_miss = 0; ic_addr = 0; ic_wait_mem = 0; ic_done = 0;
    dc_miss = 0; dc_addr = 0; dc_we = 0; dc_wdata = 0; dc_wait_mem = 0; dc_done = 0;
    pb_sel = 0; pb_ready = 0;
    @(negedge clk);
    t_reset();
    t_uncached(1'b0, 1'b0, 32'h0000_0100, 32'h0);          // R4 bank 0, wait 0
    t_uncached(1'b0, 1'b0, 32'h5000_0000, 32'h0);          // R4 bank 5, wait 15
    t_uncached(1'b0, 1'b0, 32'h6000_0004, 32'h0);          // R2 bank 6
    t_uncached(1'b1, 1'b0, 32'h9000_0020, 32'h0);          // R3 load, bit 31 ignored (bank 1)
    t_uncached(1'b1, 1'b1, 32'h4000_0010, 32'hDEAD_BEEF);  // R3 store, bank 4
    t_ignored(1'b0);
    t_ignored(1'b1);
    t_icache();
    t_dcache();
    t_periph();
    t_priority();
    summary();
    $finish;
  end
endmodule